// File: doc/BRIEF.md
# Pipelined DAC Code Calibration Engine

This block turns a raw DAC input code into a corrected code for one channel of a multi-channel source. The corrected value is the stored input code scaled by a gain code, shifted by an offset code, and clamped to the DAC's range. The result is written into a per-channel output register file. The command decoder raises `start` with a channel mask. It does this whenever an input code write finishes, and also for control updates that call for a recalculation.

The work runs in three timed stages: multiply, offset add, and saturate-and-write. Each stage has its own length in clock cycles. The stages form a pipeline, so the decoder may send the next request as soon as the current job leaves stage one, without waiting for the whole calculation to finish. A mask with several bits set queues one job per selected channel, and the jobs enter stage one one after another.

The engine reads the three source register files through a single channel index. It captures the operands when a job enters stage one. A request that arrives while stage one is occupied is dropped and reported with a one-cycle error pulse.

Top module: `cal_engine`

## Requirements
- R1: After reset, `stage1_free` is 1 and `s1_busy`, `s2_busy`, `s3_busy`, `wr_en` and `req_err` are 0.
- R2: A request sampled with `stage1_free` high and a non-zero mask makes `s1_busy` high for exactly S1 cycles per selected channel. `stage1_free` is low from the cycle after acceptance and returns high in the last cycle of the final job's stage one.
- R3: A job accepted at clock edge n writes at edge n+S1+S2+S3. `wr_en` is high for the single cycle before that edge. `wr_ch` is the job's channel and `wr_data` equals ((X1*(M+1))>>16) + C - 32768, where X1, M and C are 16-bit unsigned codes. M = 65535 gives unity gain.
- R4: A result below 0 is written as 0, and a result above 65535 is written as 65535.
- R5: A request with a non-zero mask sampled while `stage1_free` is low is dropped. It causes no write, and `req_err` goes high for exactly the next cycle.
- R6: A mask with several bits set (bit i selects channel i) runs one job per set bit in ascending channel order. Each job enters stage one S1 cycles after the previous one.
- R7: A request sampled in the last cycle of the previous job's stage one is accepted. The two jobs then overlap in the pipeline, and their writes come exactly S1 cycles apart.
- R8: A request with an all-zero mask is ignored: no error, no busy stage, no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Recalculation request strobe |
| start_mask | input | CH | Channels to recalculate, bit i = channel i |
| stage1_free | output | 1 | A request this cycle would be accepted |
| rd_ch | output | CW | Channel index for the source register file reads |
| x1_rd | input | DW | Input code of channel `rd_ch` |
| m_rd | input | DW | Gain code of channel `rd_ch` |
| c_rd | input | DW | Offset code of channel `rd_ch` |
| wr_en | output | 1 | Write strobe to the output register file |
| wr_ch | output | CW | Channel being written |
| wr_data | output | DW | Corrected code |
| s1_busy | output | 1 | Stage one holds a job |
| s2_busy | output | 1 | Stage two holds a job |
| s3_busy | output | 1 | Stage three holds a job |
| req_err | output | 1 | Previous-cycle request was dropped |

## Verification
The bench goes after several corner cases.

- **Back-to-back request.** It sends a request in exactly the cycle stage one frees. A design that frees stage one one cycle late drops that request and raises a false error.
- **Request during busy time.** It sends a request while stage one is busy. An engine that accepts it anyway corrupts the captured operands, or writes a result nobody asked for.
- **Saturation.** Operand sets drive the sum past both ends of the range. Wrong sign handling wraps these results instead of clamping them.
- **Multi-channel mask.** A sparse mask exposes channels that are issued out of order or skipped.
- **Empty mask.** An all-zero mask shows whether the design raises a spurious error or job.

// File: rtl/cal_engine.sv
module cal_engine #(
  parameter int CH = 4,
  parameter int DW = 16,
  parameter int S1 = 65,
  parameter int S2 = 65,
  parameter int S3 = 35
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CH-1:0]         start_mask,
  output logic                  stage1_free,
  output logic [$clog2(CH)-1:0] rd_ch,
  input  logic [DW-1:0]         x1_rd,
  input  logic [DW-1:0]         m_rd,
  input  logic [DW-1:0]         c_rd,
  output logic                  wr_en,
  output logic [$clog2(CH)-1:0] wr_ch,
  output logic [DW-1:0]         wr_data,
  output logic                  s1_busy,
  output logic                  s2_busy,
  output logic                  s3_busy,
  output logic                  req_err
);
  localparam int CW = $clog2(CH);
  localparam int TW = $clog2(S1 + S2 + S3 + 1);
  localparam int SW = DW + 2;

  logic [CH-1:0] pend, src;
  logic [CW-1:0] pick, ch1, ch2, ch3;
  logic [TW-1:0] c1, c2, c3;
  logic          v1, v2, v3;
  logic [DW-1:0] x1r, m1r, c1r, p2, c2r;
  logic signed [SW-1:0] sum3;
  logic [2*DW-1:0] prod;
  logic signed [SW-1:0] sum;
  logic go1, go2, go3, load, req;

  assign req  = start && (start_mask != '0);
  assign src  = (pend != '0) ? pend : start_mask;
  assign go3  = v3 && (c3 == '0);
  assign go2  = v2 && (c2 == '0) && (!v3 || go3);
  assign go1  = v1 && (c1 == '0) && (!v2 || go2);
  assign stage1_free = (!v1 || go1) && (pend == '0);
  assign load = (!v1 || go1) && ((pend != '0) || req);

  always_comb begin
    pick = '0;
    for (int i = CH - 1; i >= 0; i--)
      if (src[i]) pick = CW'(i);
  end

  assign rd_ch = pick;
  assign prod  = (2*DW)'(x1r) * ((2*DW)'(m1r) + (2*DW)'(1));
  assign sum   = $signed(SW'(p2)) + $signed(SW'(c2r)) - $signed(SW'(1) << (DW - 1));

  assign s1_busy = v1;
  assign s2_busy = v2;
  assign s3_busy = v3;
  assign wr_en   = go3;
  assign wr_ch   = ch3;
  assign wr_data = (sum3 < 0) ? '0 :
                   (sum3 > $signed(SW'({DW{1'b1}}))) ? {DW{1'b1}} : sum3[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      c1 <= '0; c2 <= '0; c3 <= '0; req_err <= 1'b0;
      ch1 <= '0; ch2 <= '0; ch3 <= '0;
      x1r <= '0; m1r <= '0; c1r <= '0; p2 <= '0; c2r <= '0; sum3 <= '0;
    end else begin
      req_err <= req && !stage1_free;

      if (load) begin
        v1 <= 1'b1; c1 <= TW'(S1 - 1); ch1 <= pick;
        x1r <= x1_rd; m1r <= m_rd; c1r <= c_rd;
        pend <= src & ~(CH'(1) << pick);
      end else if (go1) v1 <= 1'b0;
      else if (v1 && c1 != '0) c1 <= c1 - 1'b1;

      if (go1) begin
        v2 <= 1'b1; c2 <= TW'(S2 - 1); ch2 <= ch1;
        p2 <= prod[2*DW-1:DW]; c2r <= c1r;
      end else if (go2) v2 <= 1'b0;
      else if (v2 && c2 != '0) c2 <= c2 - 1'b1;

      if (go2) begin
        v3 <= 1'b1; c3 <= TW'(S3 - 1); ch3 <= ch2; sum3 <= sum;
      end else if (go3) v3 <= 1'b0;
      else if (v3 && c3 != '0) c3 <= c3 - 1'b1;
    end
  end
endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
  parameter int CH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CH-1:0] start_mask,
  input logic          stage1_free,
  input logic          s1_busy,
  input logic          s3_busy,
  input logic          wr_en,
  input logic          req_err
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_mask != '0 && stage1_free) |=> s1_busy);

  assert_idle_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_busy |-> stage1_free);

  assert_write_in_s3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> s3_busy);

  assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_mask != '0 && !stage1_free) |=> req_err);

  assert_empty_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_mask == '0) |=> !req_err);
endmodule

bind cal_engine cal_engine_chk #(.CH(CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask),
  .stage1_free(stage1_free), .s1_busy(s1_busy), .s3_busy(s3_busy),
  .wr_en(wr_en), .req_err(req_err)
);

// File: tb/cal_engine_tb.sv
module cal_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 4, DW = 16, S1 = 65, S2 = 65, S3 = 35;
  localparam int T = S1 + S2 + S3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CH-1:0] start_mask = '0;
  logic stage1_free, wr_en, s1_busy, s2_busy, s3_busy, req_err;
  logic [1:0] rd_ch, wr_ch;
  logic [DW-1:0] x1_rd, m_rd, c_rd, wr_data;
  logic [DW-1:0] x1m [CH], mm [CH], cm [CH];

  assign x1_rd = x1m[rd_ch];
  assign m_rd  = mm[rd_ch];
  assign c_rd  = cm[rd_ch];

  cal_engine #(.CH(CH), .DW(DW), .S1(S1), .S2(S2), .S3(S3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask),
    .stage1_free(stage1_free), .rd_ch(rd_ch), .x1_rd(x1_rd), .m_rd(m_rd),
    .c_rd(c_rd), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .s1_busy(s1_busy), .s2_busy(s2_busy), .s3_busy(s3_busy), .req_err(req_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, writes = 0;
  int job_l[$], job_ch[$];
  int busy_until = -1, err_at = -10;
  string cur = "R1";

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int calc(int x1, int m, int c);
    longint p = (longint'(x1) * (longint'(m) + 1)) >>> 16;
    longint v = p + c - 32768;
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return int'(v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s/%s %s: actual %0d expected %0d at cycle %0d", cur, req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit ew = 0, eb = 0;
    int ech = 0, ed = 0;
    foreach (job_l[i]) begin
      if (job_l[i] + T - 1 == cyc) begin
        ew = 1; ech = job_ch[i];
        ed = calc(x1m[ech], mm[ech], cm[ech]);
      end
      if (cyc >= job_l[i] && cyc < job_l[i] + S1) eb = 1;
    end
    chk(wr_en == ew, "R3", wr_en, ew, "wr_en");
    if (ew) begin
      writes++;
      chk(wr_ch == ech, "R6", wr_ch, ech, "wr_ch");
      chk(wr_data == ed, "R4", wr_data, ed, "wr_data");
    end
    chk(stage1_free == (cyc >= busy_until), "R2", stage1_free, cyc >= busy_until, "stage1_free");
    chk(s1_busy == eb, "R2", s1_busy, eb, "s1_busy");
    chk(req_err == (cyc == err_at), "R5", req_err, cyc == err_at, "req_err");
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic req(logic [CH-1:0] mask);
    int k = 0;
    if (mask != '0) begin
      if (cyc >= busy_until) begin
        for (int i = 0; i < CH; i++)
          if (mask[i]) begin
            job_l.push_back(cyc + 1 + k * S1); job_ch.push_back(i); k++;
          end
        busy_until = cyc + k * S1;
      end else err_at = cyc + 1;
    end
    start = 1'b1; start_mask = mask;
    tick();
    start = 1'b0; start_mask = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_free();
    while (cyc < busy_until) tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < CH; i++) begin
      x1m[i] = 16'(1000 * (i + 1)); mm[i] = 16'hFFFF; cm[i] = 16'h8000;
    end
    repeat (3) @(negedge clk);
    cur = "R1";
    chk(stage1_free && !s1_busy && !s2_busy && !s3_busy && !wr_en && !req_err,
        "R1", {stage1_free, s1_busy, s2_busy, s3_busy, wr_en, req_err}, 6'b100000, "reset outputs");
    rst_n = 1'b1;
    tick();

    cur = "R3";
    x1m[2] = 16'd40000; mm[2] = 16'd32767; cm[2] = 16'd33000;
    req(4'b0100);
    idle(T + 4);
    chk(writes == 1, "R3", writes, 1, "write count");

    cur = "R4";
    x1m[1] = 16'd0; mm[1] = 16'd0; cm[1] = 16'd0;
    req(4'b0010);
    idle(T + 4);
    x1m[1] = 16'hFFFF; mm[1] = 16'hFFFF; cm[1] = 16'hFFFF;
    req(4'b0010);
    idle(T + 4);

    cur = "R5";
    x1m[0] = 16'd12345; mm[0] = 16'd50000; cm[0] = 16'd30000;
    req(4'b0001);
    idle(10);
    req(4'b1000);
    idle(T + 4);
    chk(writes == 4, "R5", writes, 4, "no write from dropped request");

    cur = "R7";
    x1m[3] = 16'd60000; mm[3] = 16'd60000; cm[3] = 16'd100;
    req(4'b0001);
    wait_free();
    chk(stage1_free == 1'b1, "R7", stage1_free, 1, "free in last stage-one cycle");
    req(4'b1000);
    wait_free();
    req(4'b0100);
    idle(T + 4);
    chk(writes == 7, "R7", writes, 7, "overlapped writes");

    cur = "R6";
    x1m[1] = 16'd5000; mm[1] = 16'd20000; cm[1] = 16'd40000;
    req(4'b1011);
    idle(S1 + 3);
    req(4'b0100);
    idle(3 * S1 + T);
    chk(writes == 10, "R6", writes, 10, "one write per mask bit");

    cur = "R8";
    req(4'b0000);
    idle(S1 + 5);
    chk(writes == 10, "R8", writes, 10, "empty mask writes nothing");

    finish_run();
  end
endmodule